// File: doc/BRIEF.md
# DMA Request Line Generator for Paired Byte Queues

This block drives two active-low request lines toward a DMA engine that services a serial port with one receive queue and one transmit queue. Each queue holds `DEPTH` bytes. The block reads the queues' current occupancy, a receive timeout pulse and a 2-bit receive threshold code. From these it decides when the DMA engine should drain received bytes and when it should refill the transmit side.

Two control bits choose between two request styles. The first bit enables the queues and the second selects burst DMA. In single-transfer style, each line is a direct decode of occupancy. The receive line asks whenever any byte is waiting, and the transmit line asks only while the transmit queue is empty. In burst style, each line is a latch with set and clear rules, so one request covers many bytes. The receive line sets at the threshold or on a timeout and holds until the queue is drained. The transmit line sets when the queue is empty and holds until the queue is full.

Top module: `dma_rdy_gen`

## Requirements
- R1: Burst style is in force only when `q_enable`=1 and `burst_sel`=1. The other three combinations give single-transfer style, and a change of style takes effect on the outputs in the same cycle.
- R2: In single-transfer style, `rx_dreq_n` is 0 in the same cycle that `rx_level` is nonzero, and 1 when `rx_level` is 0.
- R3: In single-transfer style, `tx_dreq_n` is 0 in the same cycle that `tx_level` is 0, and 1 when `tx_level` is 1 or more.
- R4: In burst style, a cycle with `rx_level` at or above the threshold drives `rx_dreq_n` to 0 from the next clock edge.
- R5: In burst style, a cycle with `rx_timeout`=1 and nonzero `rx_level` drives `rx_dreq_n` to 0 from the next clock edge, even below the threshold.
- R6: In burst style, when `rx_level` is nonzero, below the threshold and no timeout is present, `rx_dreq_n` keeps its previous value.
- R7: A cycle with `rx_level`=0 makes `rx_dreq_n` 1 from the next edge. Clearing wins over a simultaneous timeout.
- R8: Threshold codes on `rx_thr_sel`: 0 means 1 byte, 1 means 4, 2 means 8, 3 means 14.
- R9: In burst style, a cycle with `tx_level`=0 drives `tx_dreq_n` to 0 from the next edge.
- R10: In burst style, a cycle with `tx_level`=`DEPTH` makes `tx_dreq_n` 1 from the next edge. For levels strictly between 0 and `DEPTH`, the previous value holds.
- R11: While `rst_n` is 0, and in the first cycle after it rises (until the first clock edge), both outputs are 1 whatever the inputs.
- R12: In the first cycle in which burst style is selected, both outputs are 1. Burst decisions appear from the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| q_enable | input | 1 | Queue enable control bit |
| burst_sel | input | 1 | Burst DMA select control bit |
| rx_thr_sel | input | 2 | Receive threshold code |
| rx_level | input | 5 | Receive queue occupancy, 0..DEPTH |
| tx_level | input | 5 | Transmit queue occupancy, 0..DEPTH |
| rx_timeout | input | 1 | Receive timeout event |
| rx_dreq_n | output | 1 | Receive DMA request, active low |
| tx_dreq_n | output | 1 | Transmit DMA request, active low |

## Verification
Single-transfer results and style changes are combinational. The bench drives inputs on the falling edge and samples them 1 ns later, before any rising edge. Burst results pass through one register. The bench drives on a falling edge, lets one rising edge pass, and samples at the following falling edge. The mode-entry and reset-release checks are sampled after the drive but before the next rising edge, which shows the one-cycle hold-off.

// File: rtl/dma_rdy_pkg.sv
package dma_rdy_pkg;

  typedef enum logic {
    XFER_SINGLE = 1'b0,
    XFER_BURST  = 1'b1
  } xfer_mode_e;

  localparam int unsigned THR_CODE0 = 1;
  localparam int unsigned THR_CODE1 = 4;
  localparam int unsigned THR_CODE2 = 8;
  localparam int unsigned THR_CODE3 = 14;

endpackage

// File: rtl/dma_rdy_mode_dec.sv
module dma_rdy_mode_dec
  import dma_rdy_pkg::*;
(
  input  logic       q_enable,
  input  logic       burst_sel,
  output xfer_mode_e mode
);

  // Burst style needs both bits; everything else falls back to single.
  always_comb begin
    if (q_enable && burst_sel) mode = XFER_BURST;
    else                       mode = XFER_SINGLE;
  end

endmodule

// File: rtl/dma_rdy_rx.sv
module dma_rdy_rx
  import dma_rdy_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             burst,
  input  logic [1:0]       thr_sel,
  input  logic [CNT_W-1:0] level,
  input  logic             timeout,
  output logic             dreq_n
);

  logic [CNT_W-1:0] thr_lvl;
  logic             empty;
  logic             at_thr;
  logic             hold_d;
  logic             hold_q;

  always_comb begin
    case (thr_sel)
      2'd0:    thr_lvl = CNT_W'(THR_CODE0);
      2'd1:    thr_lvl = CNT_W'(THR_CODE1);
      2'd2:    thr_lvl = CNT_W'(THR_CODE2);
      default: thr_lvl = CNT_W'(THR_CODE3);
    endcase
  end

  assign empty  = (level == '0);
  assign at_thr = (level >= thr_lvl);

  // Set/clear latch for burst style; parked inactive outside it.
  always_comb begin
    hold_d = hold_q;
    if (!burst)                   hold_d = 1'b1;
    else if (empty)               hold_d = 1'b1;
    else if (at_thr || timeout)   hold_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_q <= 1'b1;
    else        hold_q <= hold_d;
  end

  assign dreq_n = burst ? hold_q : empty;

  assert_rx_thr_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (burst && at_thr && !empty) |=> (!burst || !hold_q));

  assert_rx_tmo_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (burst && timeout && !empty) |=> (!burst || !hold_q));

  assert_rx_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (burst && !empty && !at_thr && !timeout) |=> (!burst || hold_q == $past(hold_q)));

  assert_rx_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    empty |=> hold_q);

endmodule

// File: rtl/dma_rdy_tx.sv
module dma_rdy_tx
  import dma_rdy_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             burst,
  input  logic [CNT_W-1:0] level,
  output logic             dreq_n
);

  logic empty;
  logic full;
  logic hold_d;
  logic hold_q;

  assign empty = (level == '0);
  assign full  = (level == CNT_W'(DEPTH));

  always_comb begin
    hold_d = hold_q;
    if (!burst)     hold_d = 1'b1;
    else if (full)  hold_d = 1'b1;
    else if (empty) hold_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_q <= 1'b1;
    else        hold_q <= hold_d;
  end

  assign dreq_n = burst ? hold_q : !empty;

  assert_tx_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (burst && empty) |=> (!burst || !hold_q));

  assert_tx_full_R10: assert property (@(posedge clk) disable iff (!rst_n)
    full |=> hold_q);

  assert_tx_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (burst && !empty && !full) |=> (!burst || hold_q == $past(hold_q)));

endmodule

// File: rtl/dma_rdy_gen.sv
module dma_rdy_gen
  import dma_rdy_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             q_enable,
  input  logic             burst_sel,
  input  logic [1:0]       rx_thr_sel,
  input  logic [CNT_W-1:0] rx_level,
  input  logic [CNT_W-1:0] tx_level,
  input  logic             rx_timeout,
  output logic             rx_dreq_n,
  output logic             tx_dreq_n
);

  xfer_mode_e mode;
  logic       burst;
  logic       rx_raw_n;
  logic       tx_raw_n;
  logic       armed_d;
  logic       armed_q;

  dma_rdy_mode_dec u_mode (
    .q_enable  (q_enable),
    .burst_sel (burst_sel),
    .mode      (mode)
  );

  assign burst = (mode == XFER_BURST);

  dma_rdy_rx #(.DEPTH(DEPTH)) u_rx (
    .clk     (clk),
    .rst_n   (rst_n),
    .burst   (burst),
    .thr_sel (rx_thr_sel),
    .level   (rx_level),
    .timeout (rx_timeout),
    .dreq_n  (rx_raw_n)
  );

  dma_rdy_tx #(.DEPTH(DEPTH)) u_tx (
    .clk    (clk),
    .rst_n  (rst_n),
    .burst  (burst),
    .level  (tx_level),
    .dreq_n (tx_raw_n)
  );

  // Outputs stay quiet until the first edge after reset release.
  assign armed_d = 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= armed_d;
  end

  assign rx_dreq_n = armed_q ? rx_raw_n : 1'b1;
  assign tx_dreq_n = armed_q ? tx_raw_n : 1'b1;

  assert_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !armed_q |-> (rx_dreq_n && tx_dreq_n));

  assert_single_rx_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && !(q_enable && burst_sel)) |-> (rx_dreq_n == (rx_level == '0)));

  assert_single_tx_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && !(q_enable && burst_sel)) |-> (tx_dreq_n == (tx_level != '0)));

  assert_entry_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (burst && !$past(burst)) |-> (rx_dreq_n && tx_dreq_n));

endmodule

// File: tb/dma_rdy_gen_tb.sv
module dma_rdy_gen_tb_top;

  localparam int unsigned DEPTH = 16;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  logic             clk = 1'b0;
  logic             rst_n;
  logic             q_enable;
  logic             burst_sel;
  logic [1:0]       rx_thr_sel;
  logic [CNT_W-1:0] rx_level;
  logic [CNT_W-1:0] tx_level;
  logic             rx_timeout;
  logic             rx_dreq_n;
  logic             tx_dreq_n;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  dma_rdy_gen #(.DEPTH(DEPTH)) dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .q_enable   (q_enable),
    .burst_sel  (burst_sel),
    .rx_thr_sel (rx_thr_sel),
    .rx_level   (rx_level),
    .tx_level   (tx_level),
    .rx_timeout (rx_timeout),
    .rx_dreq_n  (rx_dreq_n),
    .tx_dreq_n  (tx_dreq_n)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // one rising edge, then back to a falling edge
  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic settle();
    #1;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; q_enable = 1'b0; burst_sel = 1'b0; rx_thr_sel = 2'd0;
    rx_level = 5'd3; tx_level = 5'd0; rx_timeout = 1'b0;
    repeat (3) @(negedge clk);
    settle();
    chk("R11 rx in reset", rx_dreq_n, 1'b1);
    chk("R11 tx in reset", tx_dreq_n, 1'b1);
    @(negedge clk);
    rst_n = 1'b1;
    settle();
    chk("R11 rx after release", rx_dreq_n, 1'b1);
    chk("R11 tx after release", tx_dreq_n, 1'b1);
    step();
    chk("R2 rx single level 3", rx_dreq_n, 1'b0);
    chk("R3 tx single empty", tx_dreq_n, 1'b0);
  endtask

  task automatic t_single();
    rx_level = 5'd0; tx_level = 5'd1; settle();
    chk("R2 rx single empty", rx_dreq_n, 1'b1);
    chk("R3 tx single one byte", tx_dreq_n, 1'b1);
    rx_level = 5'd16; tx_level = 5'd16; settle();
    chk("R2 rx single full", rx_dreq_n, 1'b0);
    chk("R3 tx single full", tx_dreq_n, 1'b1);
    // enable without burst select is still single style
    q_enable = 1'b1; burst_sel = 1'b0; rx_thr_sel = 2'd3;
    rx_level = 5'd1; tx_level = 5'd0; settle();
    chk("R1 en only rx", rx_dreq_n, 1'b0);
    chk("R1 en only tx", tx_dreq_n, 1'b0);
    step();
    q_enable = 1'b0; burst_sel = 1'b1; settle();
    chk("R1 sel only rx", rx_dreq_n, 1'b0);
    chk("R1 sel only tx", tx_dreq_n, 1'b0);
    step();
  endtask

  task automatic t_burst_rx();
    rx_thr_sel = 2'd1; rx_level = 5'd0; tx_level = 5'd5; rx_timeout = 1'b0;
    q_enable = 1'b1; burst_sel = 1'b1; settle();
    chk("R12 rx entry", rx_dreq_n, 1'b1);
    chk("R12 tx entry", tx_dreq_n, 1'b1);
    step();
    rx_level = 5'd3; step();
    chk("R6 rx below threshold stays high", rx_dreq_n, 1'b1);
    rx_level = 5'd4; step();
    chk("R4 rx threshold 4 set", rx_dreq_n, 1'b0);
    rx_level = 5'd2; step();
    chk("R6 rx holds low", rx_dreq_n, 1'b0);
    rx_level = 5'd0; step();
    chk("R7 rx cleared on empty", rx_dreq_n, 1'b1);
    rx_level = 5'd1; rx_timeout = 1'b1; step();
    chk("R5 rx timeout set", rx_dreq_n, 1'b0);
    rx_timeout = 1'b0; step();
    chk("R6 rx holds after timeout", rx_dreq_n, 1'b0);
    rx_level = 5'd0; rx_timeout = 1'b1; step();
    chk("R7 rx clear beats timeout", rx_dreq_n, 1'b1);
    rx_timeout = 1'b0;
    for (int s = 0; s < 4; s++) begin
      int lvl;
      lvl = (s == 0) ? 1 : (s == 1) ? 4 : (s == 2) ? 8 : 14;
      rx_thr_sel = 2'(s);
      rx_level = CNT_W'(lvl - 1); step();
      chk("R8 below code level", rx_dreq_n, 1'b1);
      rx_level = CNT_W'(lvl); step();
      chk("R8 at code level", rx_dreq_n, 1'b0);
      rx_level = 5'd0; step();
      chk("R7 drained", rx_dreq_n, 1'b1);
    end
  endtask

  task automatic t_burst_tx();
    tx_level = 5'd5; step();
    chk("R10 tx partial stays high", tx_dreq_n, 1'b1);
    tx_level = 5'd0; step();
    chk("R9 tx empty set", tx_dreq_n, 1'b0);
    tx_level = 5'd8; step();
    chk("R10 tx holds low", tx_dreq_n, 1'b0);
    tx_level = 5'd15; step();
    chk("R10 tx holds low at 15", tx_dreq_n, 1'b0);
    tx_level = 5'd16; step();
    chk("R10 tx full clear", tx_dreq_n, 1'b1);
    tx_level = 5'd15; step();
    chk("R10 tx stays high at 15", tx_dreq_n, 1'b1);
    burst_sel = 1'b0; settle();
    chk("R1 back to single tx", tx_dreq_n, 1'b1);
    tx_level = 5'd0; settle();
    chk("R1 single tx immediate", tx_dreq_n, 1'b0);
    step();
  endtask

  initial begin
    t_reset();
    t_single();
    t_burst_rx();
    t_burst_tx();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got hang expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule